// File: doc/BRIEF.md
# Cascaded Clock-Enable Divider Tree

This block turns one root clock into a set of clock-enable strobes for five derived domains: a source divider stage, a processor domain, a main bus domain, a peripheral domain and a security domain. Each stage is an integer divider that counts pulses of its parent's enable, not root cycles. The dividers form a fixed tree. The source stage counts root cycles. The processor and main bus stages count source strobes. The peripheral and security stages count main bus strobes. Logic in each derived domain runs on the root clock and advances only on cycles where its own enable is high.

One 32-bit control register holds every ratio. Each field stores the ratio minus one. The source ratio may not be 1 while the processor ratio is also 1. When the stored value breaks that rule, a sticky error flag is raised and the processor stage runs at divide-by-2. When a stage gets a new ratio, the change waits until that stage's current period ends.

Top module: `clk_en_tree`

## Requirements
- R1: After reset the register reads 0x0001_1000 and `cfg_err_o` is 1. On the first root cycle after reset is released, all five enables are high together.
- R2: Bit 0 holds the source ratio minus one. `pll_en_o` is high once every (bit0+1) root cycles.
- R3: Bits [6:4] hold the processor ratio minus one. `cpu_en_o` is high on every (field+1)-th pulse of `pll_en_o` and is never high without it.
- R4: Bits [10:8] hold the main bus ratio minus one. `bus_en_o` is high on every (field+1)-th pulse of `pll_en_o`.
- R5: Bits [14:12] hold the peripheral ratio minus one. `per_en_o` is high on every (field+1)-th pulse of `bus_en_o` and is never high without it.
- R6: Bits [18:16] hold the security ratio minus one. `sec_en_o` is high on every (field+1)-th pulse of `bus_en_o` and is never high without it.
- R7: Bits [31:19], 15, 11, 7 and [3:1] always read 0. Writes to these bits are discarded, so the read-back of any write equals the written value ANDed with 0x0007_7771.
- R8: A write with bit 0 and bits [6:4] all zero sets `cfg_err_o`. While the flag is set, the processor stage divides by 2. The flag holds until a write that breaks that condition clears it.
- R9: When a stage's ratio is rewritten, the stage finishes its current period at the old ratio. The new ratio applies from that stage's next pulse, so no period is shortened and no pulse is repeated.
- R10: A stage with a stored value of 0 (ratio 1) produces an enable that equals its parent's enable on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Root clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read-back |
| pll_en_o | output | 1 | Source divider enable |
| cpu_en_o | output | 1 | Processor domain enable |
| bus_en_o | output | 1 | Main bus domain enable |
| per_en_o | output | 1 | Peripheral domain enable |
| sec_en_o | output | 1 | Security domain enable |
| cfg_err_o | output | 1 | Sticky illegal-ratio flag |

## Verification
If a stage counter holds a wrong value, that stage's enable comes out with the wrong phase or period. The same error then appears in every child stage below it. Each enable is compared cycle by cycle with a pulse-counting model, so a wrong count shows up within one period of the affected stage. A wrong period latched at a ratio change only appears at the stage's next terminal count, so the bench switches ratios in the middle of a period and compares the following periods. A stored register value that is wrong shows up right away on the read-back and on the error flag.

// File: rtl/clk_en_tree_pkg.sv
package clk_en_tree_pkg;
  parameter int REG_W  = 32;
  parameter int N_DOM  = 5;
  parameter int CNT_W  = 3;

  parameter int PLL_LSB = 0;
  parameter int PLL_W   = 1;
  parameter int CPU_LSB = 4;
  parameter int CPU_W   = 3;
  parameter int BUS_LSB = 8;
  parameter int BUS_W   = 3;
  parameter int PER_LSB = 12;
  parameter int PER_W   = 3;
  parameter int SEC_LSB = 16;
  parameter int SEC_W   = 3;

  parameter logic [PLL_W-1:0] PLL_RST = '0;
  parameter logic [CPU_W-1:0] CPU_RST = '0;
  parameter logic [BUS_W-1:0] BUS_RST = '0;
  parameter logic [PER_W-1:0] PER_RST = PER_W'(1);
  parameter logic [SEC_W-1:0] SEC_RST = SEC_W'(1);

  localparam logic ERR_RST = (PLL_RST == '0) && (CPU_RST == '0);

  typedef enum int {D_PLL = 0, D_CPU = 1, D_BUS = 2, D_PER = 3, D_SEC = 4} dom_e;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [PER_W-1:0] per;
    logic [BUS_W-1:0] bus;
    logic [CPU_W-1:0] cpu;
    logic [PLL_W-1:0] pll;
  } ratio_t;

  // Index into the enable vector: 0 is the root (always on), d+1 is domain d.
  function automatic int parent_of(input int d);
    case (d)
      D_PLL:        return 0;
      D_CPU, D_BUS: return 1 + D_PLL;
      default:      return 1 + D_BUS;
    endcase
  endfunction
endpackage

// File: rtl/clk_div_stage.sv
module clk_div_stage #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             parent_en_i,
  input  logic [CNT_W-1:0] ratio_m1_i,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tc_w;

  assign tc_w = (cnt_q == '0);
  assign en_o = parent_en_i & tc_w;

  // Reload samples the ratio only at terminal count: changes wait for period end.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (parent_en_i) cnt_q <= tc_w ? ratio_m1_i : cnt_q - 1'b1;
  end

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !parent_en_i |=> $stable(cnt_q));

  p_unity_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parent_en_i && tc_w && ratio_m1_i == '0) |=> (en_o == parent_en_i));
endmodule

// File: rtl/clk_en_regs.sv
module clk_en_regs
  import clk_en_tree_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ratio_t           ratio_o,
  output logic [REG_W-1:0] rd_data_o,
  output logic             cfg_err_o
);
  ratio_t ratio_q;
  logic   err_q;
  logic   illegal_w;

  assign illegal_w = (wr_data_i[PLL_LSB +: PLL_W] == '0) &&
                     (wr_data_i[CPU_LSB +: CPU_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q.pll <= PLL_RST;
      ratio_q.cpu <= CPU_RST;
      ratio_q.bus <= BUS_RST;
      ratio_q.per <= PER_RST;
      ratio_q.sec <= SEC_RST;
      err_q       <= ERR_RST;
    end else if (wr_en_i) begin
      ratio_q.pll <= wr_data_i[PLL_LSB +: PLL_W];
      ratio_q.cpu <= wr_data_i[CPU_LSB +: CPU_W];
      ratio_q.bus <= wr_data_i[BUS_LSB +: BUS_W];
      ratio_q.per <= wr_data_i[PER_LSB +: PER_W];
      ratio_q.sec <= wr_data_i[SEC_LSB +: SEC_W];
      err_q       <= illegal_w;
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[PLL_LSB +: PLL_W] = ratio_q.pll;
    rd_data_o[CPU_LSB +: CPU_W] = ratio_q.cpu;
    rd_data_o[BUS_LSB +: BUS_W] = ratio_q.bus;
    rd_data_o[PER_LSB +: PER_W] = ratio_q.per;
    rd_data_o[SEC_LSB +: SEC_W] = ratio_q.sec;
  end

  assign ratio_o   = ratio_q;
  assign cfg_err_o = err_q;

  p_err_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && illegal_w) |=> cfg_err_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_err_o));
endmodule

// File: rtl/clk_en_tree.sv
module clk_en_tree
  import clk_en_tree_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        pll_en_o,
  output logic        cpu_en_o,
  output logic        bus_en_o,
  output logic        per_en_o,
  output logic        sec_en_o,
  output logic        cfg_err_o
);
  ratio_t           ratio_w;
  logic             err_w;
  logic [N_DOM:0]   en_w;
  logic [CNT_W-1:0] ratio_m1_w [N_DOM];

  clk_en_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ratio_o   (ratio_w),
    .rd_data_o (rd_data_o),
    .cfg_err_o (err_w)
  );

  // Illegal pair: processor stage falls back to divide-by-2.
  always_comb begin
    ratio_m1_w[D_PLL] = CNT_W'(ratio_w.pll);
    ratio_m1_w[D_CPU] = err_w ? CNT_W'(1) : CNT_W'(ratio_w.cpu);
    ratio_m1_w[D_BUS] = CNT_W'(ratio_w.bus);
    ratio_m1_w[D_PER] = CNT_W'(ratio_w.per);
    ratio_m1_w[D_SEC] = CNT_W'(ratio_w.sec);
  end

  assign en_w[0] = 1'b1;

  for (genvar d = 0; d < N_DOM; d++) begin : g_stage
    clk_div_stage #(.CNT_W(CNT_W)) u_div (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .parent_en_i (en_w[parent_of(d)]),
      .ratio_m1_i  (ratio_m1_w[d]),
      .en_o        (en_w[d+1])
    );
  end

  assign pll_en_o  = en_w[1+D_PLL];
  assign cpu_en_o  = en_w[1+D_CPU];
  assign bus_en_o  = en_w[1+D_BUS];
  assign per_en_o  = en_w[1+D_PER];
  assign sec_en_o  = en_w[1+D_SEC];
  assign cfg_err_o = err_w;

  p_cpu_in_pll_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |-> pll_en_o);

  p_per_in_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |-> bus_en_o);

  p_sec_in_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_en_o |-> bus_en_o);

  p_rsv_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~32'h0007_7771) == '0);

  p_forced_div_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && pll_en_o && cpu_en_o) |=> !cpu_en_o);
endmodule

// File: tb/clk_en_tree_tb_top.sv
module clk_en_tree_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        pll_en_o, cpu_en_o, bus_en_o, per_en_o, sec_en_o, cfg_err_o;

  clk_en_tree dut_i (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [31:0] rd;
    logic        err;
    string       tag;
  } exp_t;

  exp_t  exp_q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 0;
  bit    unity = 0;
  string phase = "R2";

  // Pulse-counting model, built from the requirements.
  logic [31:0] m_cfg = 32'h0001_1000;
  logic        m_err = 1'b1;
  int          m_pos [5];
  int          m_per [5];

  function automatic int ratio_of(int d);
    case (d)
      0: return int'(m_cfg[0]) + 1;
      1: return m_err ? 2 : int'(m_cfg[6:4]) + 1;
      2: return int'(m_cfg[10:8]) + 1;
      3: return int'(m_cfg[14:12]) + 1;
      default: return int'(m_cfg[18:16]) + 1;
    endcase
  endfunction

  function automatic logic [4:0] exp_en();
    logic [4:0] e;
    e[0] = (m_pos[0] == 0);
    e[1] = e[0] && (m_pos[1] == 0);
    e[2] = e[0] && (m_pos[2] == 0);
    e[3] = e[2] && (m_pos[3] == 0);
    e[4] = e[2] && (m_pos[4] == 0);
    return e;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int d = 0; d < 5; d++) begin m_pos[d] = 0; m_per[d] = 1; end
      m_cfg = 32'h0001_1000;
      m_err = 1'b1;
    end else begin
      logic [4:0] e;
      logic [4:0] p;
      e = exp_en();
      p = {e[2], e[2], e[0], e[0], 1'b1};
      for (int d = 0; d < 5; d++) begin
        if (p[d]) begin
          if (e[d]) begin
            m_per[d] = ratio_of(d);
            m_pos[d] = (m_per[d] == 1) ? 0 : 1;
          end else begin
            m_pos[d] = (m_pos[d] + 1 >= m_per[d]) ? 0 : m_pos[d] + 1;
          end
        end
      end
      if (wr_en_i) begin
        m_cfg = wr_data_i & 32'h0007_7771;
        m_err = (wr_data_i[0] == 1'b0) && (wr_data_i[6:4] == 3'd0);
      end
    end
  end

  function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endfunction

  // Monitor: compares enables every cycle and pops register expectations.
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [4:0] e;
      logic [4:0] a;
      string      names [5];
      names = '{"R2", "R3", "R4", "R5", "R6"};
      e = exp_en();
      a = {sec_en_o, per_en_o, bus_en_o, cpu_en_o, pll_en_o};
      for (int d = 0; d < 5; d++)
        chk(a[d] == e[d], {names[d], "/", phase}, 32'(a[d]), 32'(e[d]));
      if (unity)
        chk(bus_en_o == pll_en_o && per_en_o == bus_en_o && sec_en_o == bus_en_o,
            "R10", 32'(a), {27'd0, {4{pll_en_o}}, pll_en_o});
      if (exp_q.size() > 0) begin
        exp_t x;
        x = exp_q.pop_front();
        chk(rd_data_o == x.rd, {x.tag, " read"}, rd_data_o, x.rd);
        chk(cfg_err_o == x.err, {x.tag, " err"}, 32'(cfg_err_o), 32'(x.err));
      end
    end
  end

  task automatic wr(input logic [31:0] d, input string tag);
    exp_t x;
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(posedge clk_i);
    #1;
    x.rd  = d & 32'h0007_7771;
    x.err = (d[0] == 1'b0) && (d[6:4] == 3'd0);
    x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(rd_data_o == 32'h0001_1000, "R1 reset read", rd_data_o, 32'h0001_1000);
    chk(cfg_err_o == 1'b1, "R1 reset err", 32'(cfg_err_o), 32'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk({sec_en_o, per_en_o, bus_en_o, cpu_en_o, pll_en_o} == 5'h1f, "R1 align",
        32'({sec_en_o, per_en_o, bus_en_o, cpu_en_o, pll_en_o}), 32'h1f);
    phase = "R8 forced";
    run(30);
    phase = "R2";
    wr(32'h0003_5231, "R2");
    run(200);
    phase = "R7";
    wr(32'hFFFF_FFFF, "R7");
    run(150);
    wr(32'hFFF8_888E, "R7 rsv-only");
    run(40);
    phase = "R8";
    wr(32'h0000_0000, "R8 set");
    run(40);
    wr(32'h0000_0010, "R8 clear");
    run(40);
    phase = "R10";
    wr(32'h0000_0001, "R10");
    @(negedge clk_i);
    unity = 1;
    run(20);
    @(negedge clk_i);
    unity = 0;
    phase = "R9";
    wr(32'h0007_7771, "R9 long");
    run(37);
    wr(32'h0001_0101, "R9 short");
    run(29);
    wr(32'h0006_3421, "R9 mid");
    run(120);
    @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule